// File: doc/BRIEF.md
# Mixed-Width Host to Word Register Adapter

This block sits between a host port that issues byte, word (16-bit) and long (32-bit) transfers and a register bank that only understands whole 16-bit reads and writes. Each accepted host transfer becomes one or two word operations on the bank side. Byte loads take one lane of a word read. Byte stores become a read of the containing word followed by a write-back of the merged value. Long transfers become two word transfers at consecutive word addresses.

Registers are spaced 2^STRIDE_SH bytes apart. A word operation whose byte address is not a multiple of that spacing does not reach the bank. Such a read contributes zero and such a write is lost. The host raises a request for one cycle while the adapter is idle. It then waits for a single-cycle completion pulse, and the adapter reports itself busy until then.

Top module: `regacc_adapter`

## Requirements
- R1: After reset, host_busy, host_ready, reg_rd_en and reg_wr_en are 0 and host_rdata is 0.
- R2: Every bank operation uses register index = word byte address >> STRIDE_SH. A word store at byte address A therefore lands in register A >> STRIDE_SH.
- R3: If a word address has any of its low STRIDE_SH bits set, the word read yields 0 and the word write changes no register. This applies to each word of a long or byte transfer separately.
- R4: Size code 0 is a byte. A byte load reads the word at the address with bit 0 cleared and returns, in host_rdata[7:0] with zero above, bits 7:0 of that word for an even address and bits 15:8 for an odd one.
- R5: A byte store reads the word at the address with bit 0 cleared. It then writes it back with wdata[7:0] in bits 7:0 (even address) or 15:8 (odd address), and the other byte stays unchanged. That makes one bank write, after the read.
- R6: Size code 2 is a long. A long load returns the word at A in host_rdata[15:0] and the word at A+2 in host_rdata[31:16]. Size code 1 (a word load) returns the word in host_rdata[15:0] with zero above.
- R7: A long store writes wdata[15:0] to the word at A first and wdata[31:16] to the word at A+2 in the next cycle. Address arithmetic wraps within ADDR_W bits.
- R8: A request is taken only while idle. host_busy is 1 from the cycle after acceptance until completion. host_ready pulses for one cycle: 2 clock edges after the accepting edge for long transfers and byte stores, 1 edge after it otherwise.
- R9: With STRIDE_SH = 0, no address bit is discarded and every word address reaches the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Transfer request, sampled while idle |
| host_addr | input | ADDR_W | Byte address |
| host_size | input | 2 | 0 byte, 1 word, 2 long |
| host_we | input | 1 | 1 store, 0 load |
| host_wdata | input | 32 | Store data, right-aligned |
| host_busy | output | 1 | Transfer in progress |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Load result, valid from host_ready |
| reg_idx | output | ADDR_W-STRIDE_SH | Register index |
| reg_rd_en | output | 1 | Word read strobe |
| reg_wr_en | output | 1 | Word write strobe |
| reg_wdata | output | 16 | Word write data |
| reg_rdata | input | 16 | Word read data, combinational from reg_idx |

## Verification
A sequencer that takes a wrong branch shows up within one or two cycles. The completion pulse comes early or late, or a long store produces one bank write instead of two. A stale or wrong-lane capture register shows up in the very next load result as swapped halves or a wrong byte. A wrong merge shows up at once as a changed neighbour byte in the bank. An alignment filter that is off lets a write through to a register that should be untouched, which the bank comparison after that transfer catches. Running the same transfers on a second instance with zero stride separates filtering faults from index faults.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FIRST,
      ST_SECOND,
      ST_WBACK
   } seq_state_e;
endpackage

// File: rtl/regacc_addr_map.sv
module regacc_addr_map #(
   parameter int ADDR_W    = 8,
   parameter int STRIDE_SH = 1,
   localparam int IDX_W    = ADDR_W - STRIDE_SH
) (
   input  logic [ADDR_W-1:0] word_addr,
   output logic [IDX_W-1:0]  idx,
   output logic              on_stride
);
   generate
      if (STRIDE_SH == 0) begin : g_flat
         assign idx       = word_addr;
         assign on_stride = 1'b1;
      end else begin : g_strided
         assign idx       = word_addr[ADDR_W-1:STRIDE_SH];
         assign on_stride = ~|word_addr[STRIDE_SH-1:0];
      end
   endgenerate
endmodule

// File: rtl/regacc_lanes.sv
module regacc_lanes #(
   parameter int LANE_W = 8,
   localparam int WORD_W = 2 * LANE_W
) (
   input  logic              odd,
   input  logic [WORD_W-1:0] pick_src,
   input  logic [WORD_W-1:0] merge_old,
   input  logic [LANE_W-1:0] new_lane,
   output logic [LANE_W-1:0] picked,
   output logic [WORD_W-1:0] merged
);
   always_comb begin
      if (odd) begin
         picked = pick_src[WORD_W-1:LANE_W];
         merged = {new_lane, merge_old[LANE_W-1:0]};
      end else begin
         picked = pick_src[LANE_W-1:0];
         merged = {merge_old[WORD_W-1:LANE_W], new_lane};
      end
   end
endmodule

// File: rtl/regacc_adapter.sv
module regacc_adapter
   import regacc_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int STRIDE_SH = 1,
   localparam int IDX_W    = ADDR_W - STRIDE_SH,
   localparam int LANE_W   = 8,
   localparam int WORD_W   = 2 * LANE_W,
   localparam int LONG_W   = 2 * WORD_W,
   localparam int WORD_BYTES = WORD_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [1:0]        host_size,
   input  logic              host_we,
   input  logic [LONG_W-1:0] host_wdata,
   output logic              host_busy,
   output logic              host_ready,
   output logic [LONG_W-1:0] host_rdata,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              reg_rd_en,
   output logic              reg_wr_en,
   output logic [WORD_W-1:0] reg_wdata,
   input  logic [WORD_W-1:0] reg_rdata
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("regacc_adapter: ADDR_W must be at least 2");
      end
      if (STRIDE_SH < 0 || STRIDE_SH >= ADDR_W) begin : g_bad_stride
         $error("regacc_adapter: STRIDE_SH must lie in [0, ADDR_W)");
      end
   endgenerate

   seq_state_e        state;
   logic [ADDR_W-1:0] a_q;
   acc_size_e         sz_q;
   logic              we_q;
   logic [LONG_W-1:0] wd_q;
   logic [WORD_W-1:0] lo_q;
   logic [LONG_W-1:0] rdata_q;
   logic              ready_q;

   logic [ADDR_W-1:0] base_wa, cur_wa;
   logic              on_stride;
   logic [WORD_W-1:0] rd_word, merged;
   logic [LANE_W-1:0] picked;

   // Byte transfers address their containing word.
   assign base_wa = (sz_q == SZ_BYTE) ? {a_q[ADDR_W-1:1], 1'b0} : a_q;
   assign cur_wa  = (state == ST_SECOND) ? base_wa + ADDR_W'(WORD_BYTES) : base_wa;

   regacc_addr_map #(.ADDR_W(ADDR_W), .STRIDE_SH(STRIDE_SH)) i_addr_map (
      .word_addr (cur_wa),
      .idx       (reg_idx),
      .on_stride (on_stride)
   );

   assign rd_word = on_stride ? reg_rdata : '0;

   regacc_lanes #(.LANE_W(LANE_W)) i_lanes (
      .odd       (a_q[0]),
      .pick_src  (rd_word),
      .merge_old (lo_q),
      .new_lane  (wd_q[LANE_W-1:0]),
      .picked    (picked),
      .merged    (merged)
   );

   always_comb begin
      reg_rd_en = 1'b0;
      reg_wr_en = 1'b0;
      reg_wdata = wd_q[WORD_W-1:0];
      unique case (state)
         ST_FIRST: begin
            if (we_q && sz_q != SZ_BYTE) reg_wr_en = on_stride;
            else                         reg_rd_en = on_stride;
         end
         ST_SECOND: begin
            reg_wdata = wd_q[LONG_W-1:WORD_W];
            reg_wr_en = on_stride && we_q;
            reg_rd_en = on_stride && !we_q;
         end
         ST_WBACK: begin
            reg_wdata = merged;
            reg_wr_en = on_stride;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         a_q     <= '0;
         sz_q    <= SZ_BYTE;
         we_q    <= 1'b0;
         wd_q    <= '0;
         lo_q    <= '0;
         rdata_q <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (host_req) begin
                  a_q   <= host_addr;
                  sz_q  <= acc_size_e'(host_size);
                  we_q  <= host_we;
                  wd_q  <= host_wdata;
                  state <= ST_FIRST;
               end
            end
            ST_FIRST: begin
               lo_q <= rd_word;
               if (sz_q == SZ_LONG) begin
                  state <= ST_SECOND;
               end else if (sz_q == SZ_BYTE && we_q) begin
                  state <= ST_WBACK;
               end else begin
                  state   <= ST_IDLE;
                  ready_q <= 1'b1;
                  if (!we_q) begin
                     rdata_q <= (sz_q == SZ_BYTE) ? LONG_W'(picked) : LONG_W'(rd_word);
                  end
               end
            end
            ST_SECOND: begin
               state   <= ST_IDLE;
               ready_q <= 1'b1;
               if (!we_q) rdata_q <= {rd_word, lo_q};
            end
            ST_WBACK: begin
               state   <= ST_IDLE;
               ready_q <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign host_busy  = (state != ST_IDLE);
   assign host_ready = ready_q;
   assign host_rdata = rdata_q;

   // R8: no bank traffic while idle
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !host_busy |-> (!reg_rd_en && !reg_wr_en));
   // R8: completion follows a busy cycle and lasts one cycle
   assert_ready_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> $past(host_busy));
   assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> !host_ready);
   // R6/R7: a long transfer always runs its second word
   assert_long_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIRST && sz_q == SZ_LONG) |=> (state == ST_SECOND));
   // R5: a merged write-back is preceded by the read of the same word
   assert_rmw_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WBACK && reg_wr_en) |-> ($past(reg_rd_en) && $stable(reg_idx)));
endmodule

// File: tb/test_regacc_adapter.sv
module test_regacc_adapter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        host_req = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [1:0]  host_size = '0;
   logic        host_we = 1'b0;
   logic [31:0] host_wdata = '0;

   logic        busy0, ready0, busy1, ready1;
   logic [31:0] rdata0, rdata1;
   logic [6:0]  idx0;
   logic [7:0]  idx1;
   logic        rd0, wr0, rd1, wr1;
   logic [15:0] wdat0, wdat1, rdat0, rdat1;

   regacc_adapter #(.ADDR_W(8), .STRIDE_SH(1)) i_regacc_adapter (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
      .host_size(host_size), .host_we(host_we), .host_wdata(host_wdata),
      .host_busy(busy0), .host_ready(ready0), .host_rdata(rdata0),
      .reg_idx(idx0), .reg_rd_en(rd0), .reg_wr_en(wr0), .reg_wdata(wdat0),
      .reg_rdata(rdat0));

   regacc_adapter #(.ADDR_W(8), .STRIDE_SH(0)) i_regacc_adapter_s0 (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
      .host_size(host_size), .host_we(host_we), .host_wdata(host_wdata),
      .host_busy(busy1), .host_ready(ready1), .host_rdata(rdata1),
      .reg_idx(idx1), .reg_rd_en(rd1), .reg_wr_en(wr1), .reg_wdata(wdat1),
      .reg_rdata(rdat1));

   // Bench-side register banks and write logs, one per instance
   logic [15:0] bank [2][256];
   logic [7:0]  wl_idx [2][4];
   int          wr_total [2];

   assign rdat0 = bank[0][{1'b0, idx0}];
   assign rdat1 = bank[1][idx1];

   function automatic logic [15:0] init_val(int i);
      return 16'(i * 16'h0321) ^ 16'hA55A;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) begin
            bank[0][i] <= init_val(i);
            bank[1][i] <= init_val(i);
         end
         wr_total[0] <= 0;
         wr_total[1] <= 0;
      end else begin
         if (wr0) begin
            bank[0][{1'b0, idx0}] <= wdat0;
            wl_idx[0][wr_total[0] % 4] <= {1'b0, idx0};
            wr_total[0] <= wr_total[0] + 1;
         end
         if (wr1) begin
            bank[1][idx1] <= wdat1;
            wl_idx[1][wr_total[1] % 4] <= idx1;
            wr_total[1] <= wr_total[1] + 1;
         end
      end
   end

   // Reference model
   logic [15:0] mdl [2][256];
   int n_checks = 0;
   int n_fail = 0;

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic word_ok(int d, logic [7:0] wa);
      return (d == 1) ? 1'b1 : (wa[0] == 1'b0);
   endfunction

   function automatic logic [7:0] widx(int d, logic [7:0] wa);
      return (d == 1) ? wa : (wa >> 1);
   endfunction

   task automatic mdl_do(input int d, input logic [7:0] a, input logic [1:0] sz,
                         input logic we, input logic [31:0] wd,
                         output logic [31:0] exp_rd, output int exp_nw);
      logic [7:0]  wa0, wa1;
      logic [15:0] old, lo, hi;
      exp_rd = '0;
      exp_nw = 0;
      if (sz == 2'd0) begin
         wa0 = {a[7:1], 1'b0};
         old = word_ok(d, wa0) ? mdl[d][widx(d, wa0)] : 16'h0;
         if (!we) exp_rd = {24'h0, a[0] ? old[15:8] : old[7:0]};
         else if (word_ok(d, wa0)) begin
            mdl[d][widx(d, wa0)] = a[0] ? {wd[7:0], old[7:0]} : {old[15:8], wd[7:0]};
            exp_nw = 1;
         end
      end else if (sz == 2'd2) begin
         wa0 = a;
         wa1 = a + 8'd2;
         if (!we) begin
            lo = word_ok(d, wa0) ? mdl[d][widx(d, wa0)] : 16'h0;
            hi = word_ok(d, wa1) ? mdl[d][widx(d, wa1)] : 16'h0;
            exp_rd = {hi, lo};
         end else begin
            if (word_ok(d, wa0)) begin mdl[d][widx(d, wa0)] = wd[15:0]; exp_nw++; end
            if (word_ok(d, wa1)) begin mdl[d][widx(d, wa1)] = wd[31:16]; exp_nw++; end
         end
      end else begin
         wa0 = a;
         if (!we) exp_rd = {16'h0, word_ok(d, wa0) ? mdl[d][widx(d, wa0)] : 16'h0};
         else if (word_ok(d, wa0)) begin mdl[d][widx(d, wa0)] = wd[15:0]; exp_nw = 1; end
      end
   endtask

   task automatic run(input logic [7:0] a, input logic [1:0] sz, input logic we, input logic [31:0] wd);
      logic [31:0] exp_rd [2];
      int exp_nw [2];
      int st [2];
      int n, lat;
      for (int d = 0; d < 2; d++) begin
         mdl_do(d, a, sz, we, wd, exp_rd[d], exp_nw[d]);
      end
      @(negedge clk);
      st[0] = wr_total[0];
      st[1] = wr_total[1];
      host_req = 1'b1; host_addr = a; host_size = sz; host_we = we; host_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      host_req = 1'b0;
      chk(busy0 && busy1, "R8 busy after accept", {30'h0, busy1, busy0}, 32'h3);
      lat = (sz == 2'd2 || (sz == 2'd0 && we)) ? 2 : 1;
      n = 0;
      while (!ready0 && n < 8) begin
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      chk(n == lat && ready1, "R8 completion latency", n, lat);
      for (int d = 0; d < 2; d++) begin
         logic [7:0] wa0, wa1;
         wa0 = (sz == 2'd0) ? {a[7:1], 1'b0} : a;
         wa1 = a + 8'd2;
         if (!we) begin
            chk(((d == 0) ? rdata0 : rdata1) == exp_rd[d],
                (sz == 2'd0) ? "R4 byte load" : (sz == 2'd2) ? "R6 long load" : "R3 R9 word load",
                (d == 0) ? rdata0 : rdata1, exp_rd[d]);
         end else begin
            chk(wr_total[d] - st[d] == exp_nw[d], (sz == 2'd0) ? "R5 byte store write count" : "R3 write count",
                wr_total[d] - st[d], exp_nw[d]);
            chk(bank[d][widx(d, wa0)] == mdl[d][widx(d, wa0)], "R2 R3 R5 bank word",
                {16'h0, bank[d][widx(d, wa0)]}, {16'h0, mdl[d][widx(d, wa0)]});
            if (sz == 2'd2) begin
               chk(bank[d][widx(d, wa1)] == mdl[d][widx(d, wa1)], "R7 bank upper word",
                   {16'h0, bank[d][widx(d, wa1)]}, {16'h0, mdl[d][widx(d, wa1)]});
               if (exp_nw[d] == 2) begin
                  chk(wl_idx[d][st[d] % 4] == widx(d, wa0) && wl_idx[d][(st[d] + 1) % 4] == widx(d, wa1),
                      "R7 store order", {wl_idx[d][st[d] % 4], wl_idx[d][(st[d] + 1) % 4]},
                      {widx(d, wa0), widx(d, wa1)});
               end
            end
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) begin
         mdl[0][i] = init_val(i);
         mdl[1][i] = init_val(i);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(!busy0 && !ready0 && rdata0 == 0 && !rd0 && !wr0, "R1 reset state", rdata0, 0);
      chk(!busy1 && !ready1 && rdata1 == 0 && !rd1 && !wr1, "R1 reset state s0", rdata1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 index mapping
      run(8'h10, 2'd1, 1'b1, 32'h0000BEEF);
      chk(bank[0][8] == 16'hBEEF, "R2 index stride 2", {16'h0, bank[0][8]}, 32'hBEEF);
      chk(bank[1][16] == 16'hBEEF, "R9 index stride 1", {16'h0, bank[1][16]}, 32'hBEEF);
      run(8'h10, 2'd1, 1'b0, 32'h0);
      // R3 misaligned word, R9 same address reaches bank with zero stride
      run(8'h13, 2'd1, 1'b0, 32'h0);
      run(8'h13, 2'd1, 1'b1, 32'h00001234);
      chk(bank[0][9] == init_val(9), "R3 misaligned store ignored", {16'h0, bank[0][9]}, {16'h0, init_val(9)});
      chk(bank[1][8'h13] == 16'h1234, "R9 zero stride store", {16'h0, bank[1][8'h13]}, 32'h1234);
      // R4 byte lanes, R5 merge
      run(8'h20, 2'd0, 1'b0, 32'h0);
      run(8'h21, 2'd0, 1'b0, 32'h0);
      run(8'h21, 2'd0, 1'b1, 32'h00000077);
      run(8'h20, 2'd0, 1'b1, 32'h00000011);
      run(8'h20, 2'd1, 1'b0, 32'h0);
      // R6 R7 long transfers, including wrap
      run(8'h40, 2'd2, 1'b1, 32'h12345678);
      run(8'h40, 2'd2, 1'b0, 32'h0);
      run(8'hFE, 2'd2, 1'b1, 32'hCAFEF00D);
      run(8'hFE, 2'd2, 1'b0, 32'h0);
      run(8'h41, 2'd2, 1'b1, 32'hDEAD0001);
      run(8'h41, 2'd2, 1'b0, 32'h0);
      // Random mix
      for (int k = 0; k < 600; k++) begin
         run(8'($urandom), 2'($urandom % 3), 1'($urandom), $urandom);
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule